// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filter

This block is an asynchronous serial receiver for a shared multidrop line. It takes in frames with 8 data bits or 9 data bits. Each line sample is qualified by a tick input that runs at sixteen times the bit rate. When the node-select enable is set, the block checks each incoming address frame against the node's own address. It raises its receive-complete flag only when the frame is meant for this node, so the processor sees nothing of traffic sent to other nodes.

Each node answers to two addresses, both formed from an address register and a mask register. The first is the individual address, compared only at the bit positions where the mask holds 1. The second is a broadcast address, formed as the OR of the two registers. In the 8-bit framing with the filter on, the stop bit takes the role of the ninth bit. Software clears the flag through a dedicated clear input.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, rx_done, rx_data and rx_bit9 are all 0.
- R2: The idle line is high. A frame is a low start bit, then data bits LSB first, then (only when mode[1]=1) a ninth bit, then a high stop bit. Each bit lasts 16 ticks. Mode codes 0 and 1 carry 8 data bits; codes 2 and 3 carry 9 bits.
- R3: With the filter inactive, every frame with a high stop bit sets rx_done and stores its byte in rx_data. In modes 2/3 the ninth bit goes to rx_bit9; in modes 0/1 the stop bit does.
- R4: The filter is active when mp_en=1 and mode is not 0. While it is active, a byte matches the individual address if it equals node_addr at every position where node_mask is 1. Positions where node_mask is 0 are ignored.
- R5: With node_mask = 8'hFF, the individual address matches only the exact value of node_addr.
- R6: While the filter is active, a byte also matches when it has a 1 at every position where (node_addr | node_mask) is 1.
- R7: In modes 2/3 with the filter active, a frame sets rx_done only if its ninth bit is 1 and the byte matches. Frames with ninth bit 0 are dropped.
- R8: In mode 1 with the filter active, the stop bit stands in for the ninth bit. A matching address with a low stop bit does not set rx_done.
- R9: In mode 0, mp_en has no effect, and frames that do not match are still accepted.
- R10: rx_data and rx_bit9 change only on a frame that sets rx_done. A frame that ends while rx_done is already set is dropped.
- R11: rx_done stays set until rx_done_clr is high. It then reads 0 on the next cycle, and the clear wins over a frame that ends in the same cycle.
- R12: A start bit that no longer reads low at mid-bit sends the receiver back to idle without a frame.
- R13: Each bit is decided by a majority vote over samples 7, 8 and 9 of its 16, so one corrupted sample does not change the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Sample strobe at 16x the bit rate |
| rxd | input | 1 | Serial line |
| mode | input | 2 | Frame mode (0,1: 8 bits; 2,3: 9 bits) |
| mp_en | input | 1 | Address filter enable |
| node_addr | input | 8 | Node address register |
| node_mask | input | 8 | Node address mask (1 = compared) |
| rx_done_clr | input | 1 | Clears rx_done |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit (or stop bit) of last accepted frame |
| rx_done | output | 1 | Receive-complete flag |

## Verification
The bench builds the block with its default 8-bit data width and 16 samples per bit. This keeps the received address space small enough to sweep all 256 bytes against fixed address and mask settings. The sweeps cover a partially masked node, an exact-match node in 9-bit framing, and a slice of the 8-bit framing where the stop bit acts as the address marker. With the tick set to every clock, a frame takes about 180 cycles. That budget leaves room for directed cases on mid-bit glitches, false starts, bad stop bits and frames that arrive while the flag is held.

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic [1:0]    mode,
  input  logic          mp_en,
  input  logic [DW-1:0] node_addr,
  input  logic [DW-1:0] node_mask,
  input  logic          rx_done_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_done
);
  localparam int CW  = $clog2(OVS);
  localparam int IW  = $clog2(DW + 2);
  localparam int MID = OVS / 2 + 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} st_t;

  st_t           st;
  logic [1:0]    sync, hist;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx, last_idx;
  logic [DW-1:0] sh;
  logic          b9;

  wire rx_s   = sync[1];
  wire vote   = (hist[1] & hist[0]) | (hist[1] & rx_s) | (hist[0] & rx_s);
  wire at_mid = tick && (cnt == CW'(MID));

  assign last_idx = mode[1] ? IW'(DW + 1) : IW'(DW);

  wire fin       = at_mid && (st == S_BITS) && (idx == last_idx);
  wire filt      = mp_en && (mode != 2'd0);
  wire ninth     = mode[1] ? b9 : vote;
  wire hit_given = ((sh ^ node_addr) & node_mask) == '0;
  wire hit_bcast = ((node_addr | node_mask) & ~sh) == '0;
  wire accept    = vote && (!filt || (ninth && (hit_given || hit_bcast)));
  wire load      = fin && accept && !rx_done && !rx_done_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      hist <= 2'b11;
    end else begin
      sync <= {sync[0], rxd};
      if (tick) hist <= {hist[0], rx_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
      b9  <= 1'b0;
    end else if (tick) begin
      cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (!rx_s) begin
          st  <= S_START;
          cnt <= CW'(1);
        end
        S_START: if (at_mid) begin
          idx <= '0;
          st  <= vote ? S_IDLE : S_BITS;
        end
        S_BITS: if (at_mid) begin
          if (idx < IW'(DW)) sh <= {vote, sh[DW-1:1]};
          else if (idx == IW'(DW) && mode[1]) b9 <= vote;
          idx <= idx + 1'b1;
          if (idx == last_idx) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_done <= 1'b0;
      rx_data <= '0;
      rx_bit9 <= 1'b0;
    end else begin
      if (rx_done_clr) rx_done <= 1'b0;
      else if (load)   rx_done <= 1'b1;
      if (load) begin
        rx_data <= sh;
        rx_bit9 <= ninth;
      end
    end
  end
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          mp_en,
  input logic [DW-1:0] node_addr,
  input logic [DW-1:0] node_mask,
  input logic          rx_done_clr,
  input logic [DW-1:0] rx_data,
  input logic          rx_bit9,
  input logic          rx_done
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_done_clr) |=> rx_done);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_clr |=> !rx_done);

  p_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(rx_data) && $stable(rx_bit9)) |-> $rose(rx_done));

  p_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done) && $past(mp_en) && $past(mode) != 2'd0 &&
     $stable(node_addr) && $stable(node_mask))
    |-> ((((rx_data ^ node_addr) & node_mask) == '0) ||
         (((node_addr | node_mask) & ~rx_data) == '0)));

  p_ninth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done) && $past(mp_en) && $past(mode) != 2'd0) |-> rx_bit9);
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mp_en(mp_en),
  .node_addr(node_addr), .node_mask(node_mask), .rx_done_clr(rx_done_clr),
  .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done)
);

// File: tb/tb_uart_addr_rx.sv
module tb_uart_addr_rx;
  logic       clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, mp_en = 1'b0, clr = 1'b0;
  logic [1:0] mode = 2'd3;
  logic [7:0] addr = 8'h00, mask = 8'h00;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_done, tick;
  int tdiv = 1, tc = 0, tests = 0, fails = 0;
  logic [7:0] pd = 8'h00;
  logic       pb = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) tc <= (tc + 1 >= tdiv) ? 0 : tc + 1;
  assign tick = (tc == 0);

  uart_addr_rx dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mode(mode), .mp_en(mp_en),
    .node_addr(addr), .node_mask(mask), .rx_done_clr(clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exp_acc(logic [7:0] d, logic b9, logic stp);
    bit filt  = mp_en && (mode != 2'd0);
    bit ninth = mode[1] ? b9 : stp;
    bit given = ((d ^ addr) & mask) == 8'h00;
    bit bc    = ((addr | mask) & ~d) == 8'h00;
    return stp && (!filt || (ninth && (given || bc)));
  endfunction

  task automatic drive_bit(input logic v, input bit glitch);
    for (int k = 0; k < 16 * tdiv; k++) begin
      rxd = (glitch && k == 8) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic frame(input logic [7:0] d, input logic b9, input logic stp, input int gbit);
    drive_bit(1'b0, gbit == 0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], gbit == i + 1);
    if (mode[1]) drive_bit(b9, 1'b0);
    drive_bit(stp, 1'b0);
    rxd = 1'b1;
    repeat (stp ? 4 : 40) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run(input string tag, input logic [7:0] d, input logic b9,
                     input logic stp, input int gbit);
    bit a;
    a = exp_acc(d, b9, stp);
    frame(d, b9, stp, gbit);
    if (a) begin
      pd = d;
      pb = mode[1] ? b9 : stp;
    end
    chk(tag, {6'd0, rx_done, rx_bit9, rx_data}, {6'd0, a, pb, pd});
    if (rx_done) pulse_clr();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset", {7'd0, rx_done, rx_bit9, rx_data}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    mode = 2'd3; mp_en = 1'b0;
    run("R3 mode3 nofilter b9=0", 8'h3C, 1'b0, 1'b1, -1);
    run("R3 mode3 nofilter b9=1", 8'hA5, 1'b1, 1'b1, -1);
    mode = 2'd1;
    run("R3 mode1 nofilter", 8'h81, 1'b0, 1'b1, -1);
    run("R3 mode1 bad stop", 8'h42, 1'b0, 1'b0, -1);
    tdiv = 3; mode = 2'd2;
    run("R2 slow tick mode2", 8'h96, 1'b1, 1'b1, -1);
    tdiv = 1;

    mode = 2'd0;
    run("R13 glitch on data bit", 8'h55, 1'b0, 1'b1, 4);
    run("R13 glitch on start bit", 8'hC3, 1'b0, 1'b1, 0);

    mode = 2'd3; mp_en = 1'b1; addr = 8'hF1; mask = 8'hFA;
    run("R4 accept F0", 8'hF0, 1'b1, 1'b1, -1);
    run("R4 accept F1", 8'hF1, 1'b1, 1'b1, -1);
    run("R4 reject F3", 8'hF3, 1'b1, 1'b1, -1);
    run("R7 ninth bit 0 dropped", 8'hF0, 1'b0, 1'b1, -1);
    for (int v = 0; v < 256; v++) run("R4/R6 sweep F1/FA", 8'(v), 1'b1, 1'b1, -1);

    mode = 2'd2; addr = 8'h5A; mask = 8'hFF;
    for (int v = 0; v < 256; v++) run("R5 exact sweep", 8'(v), 1'b1, 1'b1, -1);

    mode = 2'd3; addr = 8'h56; mask = 8'hFC;
    run("R6 broadcast FE", 8'hFE, 1'b1, 1'b1, -1);
    run("R6 broadcast miss 7E", 8'h7E, 1'b1, 1'b1, -1);

    mode = 2'd1; addr = 8'hF1; mask = 8'hFA;
    run("R8 match bad stop", 8'hF0, 1'b0, 1'b0, -1);
    run("R8 match good stop", 8'hF0, 1'b0, 1'b1, -1);
    run("R8 mismatch", 8'hF3, 1'b0, 1'b1, -1);
    addr = 8'h56; mask = 8'hFC;
    for (int v = 8'h40; v < 8'h80; v++) run("R8 mode1 sweep", 8'(v), 1'b0, 1'b1, -1);

    mode = 2'd0; addr = 8'hF1; mask = 8'hFA;
    run("R9 mode0 ignores filter", 8'hF3, 1'b0, 1'b1, -1);

    mp_en = 1'b0; mode = 2'd3;
    frame(8'h11, 1'b1, 1'b1, -1);
    chk("R11 flag set", {14'd0, rx_done, rx_bit9}, 16'h0003);
    frame(8'h22, 1'b0, 1'b1, -1);
    chk("R10 frame while flag set dropped", {6'd0, rx_done, rx_bit9, rx_data}, 16'h0311);
    repeat (20) @(negedge clk);
    chk("R11 flag held", {15'd0, rx_done}, 16'h0001);
    pulse_clr();
    chk("R11 clear", {15'd0, rx_done}, 16'h0000);
    pd = 8'h11; pb = 1'b1;

    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (60) @(negedge clk);
    chk("R12 false start", {6'd0, rx_done, rx_bit9, rx_data}, 16'h0111);
    run("R12 frame after false start", 8'h6B, 1'b0, 1'b1, -1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule